// File: doc/BRIEF.md
# CAN Receive Acceptance Mask Filter

This block decides whether a received CAN identifier is accepted by one receive target. A target is either a receive message buffer or an element of the identifier filter table that feeds the receive FIFO. The caller presents the received identifier, the target's stored filter identifier, the target index and a flag saying which kind of target it is. One clock later the block returns a match flag.

The mask applied depends on the target. A shared mask covers most targets. Two dedicated masks cover buffers 14 and 15. When the FIFO is enabled, those same two masks also cover filter elements 6 and 7. An individual-mask mode replaces all three stored masks with a mask supplied on an input port for each lookup. The caller looks that mask up for the target, and the block does not store it. The three stored masks can be written only while the controller is frozen.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the shared mask and both dedicated masks hold all ones, so every identifier bit must equal the filter bit.
- R2: A message buffer with an index other than 14 or 15 is compared under the shared mask.
- R3: Buffer 14 is compared under the first dedicated mask, and buffer 15 under the second dedicated mask.
- R4: With the FIFO enabled, a filter element with an index other than 6 or 7 is compared under the shared mask.
- R5: With the FIFO enabled, filter element 6 is compared under the first dedicated mask, and element 7 under the second dedicated mask.
- R6: When `indiv_mode` is 1, the stored masks have no effect, and every valid target is compared under `indiv_mask`.
- R7: A mask write takes effect only when `cfg_we` and `freeze` are both 1 and `cfg_tgt` is 0 (shared), 1 (dedicated for buffer 14 / element 6) or 2 (dedicated for buffer 15 / element 7). Any other write, including `cfg_tgt` = 3, leaves every mask unchanged.
- R8: A target matches exactly when ((rx_id XOR filt_id) AND mask) is zero. A mask bit of 1 requires equality at that position, and a mask bit of 0 is a don't-care.
- R9: `match_valid` is `lk_valid` delayed by one clock. `match` is 0 whenever `match_valid` is 0, and both are 0 after reset.
- R10: An invalid target never matches. A buffer target is invalid when its index is 40 or more. A filter target (`lk_fifo` = 1) is invalid when the FIFO is disabled or its index is 8 or more.
- R11: A lookup in the same cycle as an accepted mask write is judged with the mask value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Controller is in freeze mode; mask writes are allowed |
| indiv_mode | input | 1 | Use the per-lookup individual mask instead of the stored masks |
| fifo_en | input | 1 | Receive FIFO and its filter table are enabled |
| cfg_we | input | 1 | Mask write strobe |
| cfg_tgt | input | 2 | Mask register selected: 0 shared, 1 dedicated A, 2 dedicated B, 3 reserved |
| cfg_wdata | input | 32 | Mask write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_fifo | input | 1 | 1: target is a filter table element; 0: target is a message buffer |
| lk_idx | input | 6 | Target index |
| rx_id | input | 32 | Received identifier |
| filt_id | input | 32 | Stored filter identifier of the target |
| indiv_mask | input | 32 | Mask of the target, used in individual-mask mode |
| match_valid | output | 1 | Result strobe, one cycle after `lk_valid` |
| match | output | 1 | Identifier accepted by the target |

## Verification
A mask write and a lookup can fall in the same cycle. The question is then whether the comparison sees the old mask or the new one. The bench provokes this with a directed case: while frozen, it writes all ones to the shared mask and in the same cycle looks up a buffer whose identifiers differ only in bits the old mask ignored. It then repeats the lookup one cycle later. The random phase also mixes writes, freeze toggles and lookups in the same cycles. A bench model updates its copy of each mask only after the edge on which it judged the lookup, and every result is compared against that model.

// File: rtl/can_accf_pkg.sv
package can_accf_pkg;

  localparam int NUM_MASK_REGS = 3;

  // mask register slot addressed by a configuration write
  typedef enum logic [1:0] {
    CFG_SHARED = 2'd0,
    CFG_DED_A  = 2'd1,
    CFG_DED_B  = 2'd2,
    CFG_RSVD   = 2'd3
  } cfg_tgt_e;

  // which mask source a lookup is judged under
  typedef enum logic [2:0] {
    MSEL_SHARED,
    MSEL_DED_A,
    MSEL_DED_B,
    MSEL_INDIV,
    MSEL_NONE
  } msel_e;

endpackage

// File: rtl/can_accf_mask_regs.sv
module can_accf_mask_regs
  import can_accf_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freeze,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_tgt,
  input  logic [ID_W-1:0] cfg_wdata,
  output logic [ID_W-1:0] shared_mask,
  output logic [ID_W-1:0] ded_a_mask,
  output logic [ID_W-1:0] ded_b_mask
);

  // write is honoured only in freeze mode and for an existing slot
  logic wr_ok;
  assign wr_ok = cfg_we && freeze && (cfg_tgt != CFG_RSVD);

  logic [ID_W-1:0] mask_q [NUM_MASK_REGS];
  logic [NUM_MASK_REGS-1:0] wr_hit;

  for (genvar k = 0; k < NUM_MASK_REGS; k++) begin : g_mreg
    assign wr_hit[k] = wr_ok && (cfg_tgt == 2'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[k] <= '1;
      else if (wr_hit[k])
        mask_q[k] <= cfg_wdata;
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze |=> $stable(mask_q[k]));  // R7
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tgt == CFG_RSVD) |=> $stable(mask_q[k]));  // R7
  end

  assign shared_mask = mask_q[0];
  assign ded_a_mask  = mask_q[1];
  assign ded_b_mask  = mask_q[2];

  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));  // R7

endmodule

// File: rtl/can_accf_mask_sel.sv
module can_accf_mask_sel
  import can_accf_pkg::*;
#(
  parameter int ID_W      = 32,
  parameter int IDX_W     = 6,
  parameter int NUM_MB    = 40,
  parameter int NUM_FLT   = 8,
  parameter int DED_MB_A  = 14,
  parameter int DED_MB_B  = 15,
  parameter int DED_FLT_A = 6,
  parameter int DED_FLT_B = 7
) (
  input  logic             indiv_mode,
  input  logic             fifo_en,
  input  logic             tgt_fifo,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic [ID_W-1:0]  shared_mask,
  input  logic [ID_W-1:0]  ded_a_mask,
  input  logic [ID_W-1:0]  ded_b_mask,
  input  logic [ID_W-1:0]  indiv_mask,
  output logic             tgt_ok,
  output logic [ID_W-1:0]  sel_mask
);

  localparam logic [IDX_W:0]   MB_LIM  = (IDX_W+1)'(NUM_MB);
  localparam logic [IDX_W:0]   FLT_LIM = (IDX_W+1)'(NUM_FLT);
  localparam logic [IDX_W-1:0] MB_A    = IDX_W'(DED_MB_A);
  localparam logic [IDX_W-1:0] MB_B    = IDX_W'(DED_MB_B);
  localparam logic [IDX_W-1:0] FLT_A   = IDX_W'(DED_FLT_A);
  localparam logic [IDX_W-1:0] FLT_B   = IDX_W'(DED_FLT_B);

  // does the index name a real buffer or a live filter element
  function automatic logic target_exists(input logic is_flt, input logic fen,
                                         input logic [IDX_W-1:0] idx);
    if (is_flt) return fen && ({1'b0, idx} < FLT_LIM);
    else        return {1'b0, idx} < MB_LIM;
  endfunction

  // mask source for an existing target under the stored-mask scheme
  function automatic msel_e stored_source(input logic is_flt,
                                          input logic [IDX_W-1:0] idx);
    if (is_flt) begin
      if (idx == FLT_A) return MSEL_DED_A;
      if (idx == FLT_B) return MSEL_DED_B;
    end else begin
      if (idx == MB_A) return MSEL_DED_A;
      if (idx == MB_B) return MSEL_DED_B;
    end
    return MSEL_SHARED;
  endfunction

  msel_e msel;

  always_comb begin
    tgt_ok = target_exists(tgt_fifo, fifo_en, tgt_idx);
    if (!tgt_ok)         msel = MSEL_NONE;
    else if (indiv_mode) msel = MSEL_INDIV;
    else                 msel = stored_source(tgt_fifo, tgt_idx);
  end

  always_comb begin
    unique case (msel)
      MSEL_SHARED: sel_mask = shared_mask;
      MSEL_DED_A:  sel_mask = ded_a_mask;
      MSEL_DED_B:  sel_mask = ded_b_mask;
      MSEL_INDIV:  sel_mask = indiv_mask;
      default:     sel_mask = '1;
    endcase
  end

  always_comb begin
    AST_NONE_ONLY_WHEN_BAD: assert (tgt_ok || (msel == MSEL_NONE));  // R10
  end

endmodule

// File: rtl/can_accf_cmp.sv
module can_accf_cmp #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            tgt_ok,
  input  logic [ID_W-1:0] rx_id,
  input  logic [ID_W-1:0] filt_id,
  input  logic [ID_W-1:0] mask,
  output logic            match_valid,
  output logic            match
);

  // every bit the mask cares about must agree
  function automatic logic id_accept(input logic [ID_W-1:0] a,
                                     input logic [ID_W-1:0] b,
                                     input logic [ID_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  logic hit_now;
  assign hit_now = strobe && tgt_ok && id_accept(rx_id, filt_id, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      match       <= 1'b0;
    end else begin
      match_valid <= strobe;
      match       <= hit_now;
    end
  end

  AST_NO_STROBE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> !match);  // R9
  AST_MASKED_DIFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (((rx_id ^ filt_id) & mask) != '0)) |=> !match);  // R8

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_accf_pkg::*;
#(
  parameter int ID_W      = 32,
  parameter int IDX_W     = 6,
  parameter int NUM_MB    = 40,
  parameter int NUM_FLT   = 8,
  parameter int DED_MB_A  = 14,
  parameter int DED_MB_B  = 15,
  parameter int DED_FLT_A = 6,
  parameter int DED_FLT_B = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             indiv_mode,
  input  logic             fifo_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_tgt,
  input  logic [ID_W-1:0]  cfg_wdata,
  input  logic             lk_valid,
  input  logic             lk_fifo,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [ID_W-1:0]  rx_id,
  input  logic [ID_W-1:0]  filt_id,
  input  logic [ID_W-1:0]  indiv_mask,
  output logic             match_valid,
  output logic             match
);

  logic [ID_W-1:0] shared_mask, ded_a_mask, ded_b_mask, sel_mask;
  logic            tgt_ok;

  can_accf_mask_regs #(.ID_W(ID_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze      (freeze),
    .cfg_we      (cfg_we),
    .cfg_tgt     (cfg_tgt),
    .cfg_wdata   (cfg_wdata),
    .shared_mask (shared_mask),
    .ded_a_mask  (ded_a_mask),
    .ded_b_mask  (ded_b_mask)
  );

  can_accf_mask_sel #(
    .ID_W(ID_W), .IDX_W(IDX_W), .NUM_MB(NUM_MB), .NUM_FLT(NUM_FLT),
    .DED_MB_A(DED_MB_A), .DED_MB_B(DED_MB_B),
    .DED_FLT_A(DED_FLT_A), .DED_FLT_B(DED_FLT_B)
  ) u_sel (
    .indiv_mode  (indiv_mode),
    .fifo_en     (fifo_en),
    .tgt_fifo    (lk_fifo),
    .tgt_idx     (lk_idx),
    .shared_mask (shared_mask),
    .ded_a_mask  (ded_a_mask),
    .ded_b_mask  (ded_b_mask),
    .indiv_mask  (indiv_mask),
    .tgt_ok      (tgt_ok),
    .sel_mask    (sel_mask)
  );

  can_accf_cmp #(.ID_W(ID_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (lk_valid),
    .tgt_ok      (tgt_ok),
    .rx_id       (rx_id),
    .filt_id     (filt_id),
    .mask        (sel_mask),
    .match_valid (match_valid),
    .match       (match)
  );

  AST_MATCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> match_valid);  // R9
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !match_valid);  // R9
  AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !tgt_ok) |=> !match);  // R10
  AST_INDIV_MASK_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && tgt_ok && indiv_mode) |-> (sel_mask == indiv_mask));  // R6
  AST_DED_A_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !indiv_mode && !lk_fifo && lk_idx == IDX_W'(DED_MB_A))
      |-> (sel_mask == ded_a_mask));  // R3
  AST_DED_B_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !indiv_mode && lk_fifo && fifo_en && lk_idx == IDX_W'(DED_FLT_B))
      |-> (sel_mask == ded_b_mask));  // R5

endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 0, indiv_mode = 0, fifo_en = 0, cfg_we = 0;
  logic [1:0]  cfg_tgt = 0;
  logic [31:0] cfg_wdata = 0;
  logic        lk_valid = 0, lk_fifo = 0;
  logic [5:0]  lk_idx = 0;
  logic [31:0] rx_id = 0, filt_id = 0, indiv_mask = 0;
  logic        match_valid, match;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_sh = '1, m_a = '1, m_b = '1;

  always #10 clk = ~clk;

  can_accept_filter uut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .indiv_mode(indiv_mode),
    .fifo_en(fifo_en), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_wdata(cfg_wdata),
    .lk_valid(lk_valid), .lk_fifo(lk_fifo), .lk_idx(lk_idx), .rx_id(rx_id),
    .filt_id(filt_id), .indiv_mask(indiv_mask),
    .match_valid(match_valid), .match(match)
  );

  // bitwise restatement of the acceptance rule (R8)
  function automatic logic ref_accept(logic [31:0] a, logic [31:0] b, logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (m[i] && (a[i] != b[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic ref_match(logic fl, logic [5:0] ix);
    logic [31:0] m;
    if (fl && (!fifo_en || ix > 7)) return 1'b0;   // R10
    if (!fl && ix > 39) return 1'b0;               // R10
    if (indiv_mode) m = indiv_mask;                // R6
    else if (fl) m = (ix == 6) ? m_a : (ix == 7) ? m_b : m_sh;   // R4 R5
    else         m = (ix == 14) ? m_a : (ix == 15) ? m_b : m_sh; // R2 R3
    return ref_accept(rx_id, filt_id, m);
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // drive at negedge, judge after the following posedge
  task automatic step(string tag, logic v, logic fl, logic [5:0] ix,
                      logic [31:0] rx, logic [31:0] fi);
    logic exp_m;
    lk_valid = v; lk_fifo = fl; lk_idx = ix; rx_id = rx; filt_id = fi;
    exp_m = v && ref_match(fl, ix);
    @(posedge clk);
    if (cfg_we && freeze && cfg_tgt != 2'd3) begin
      case (cfg_tgt)
        2'd0: m_sh = cfg_wdata;
        2'd1: m_a  = cfg_wdata;
        default: m_b = cfg_wdata;
      endcase
    end
    @(negedge clk);
    check(tag, match_valid, v, "match_valid");
    check(tag, match, exp_m, "match");
    cfg_we = 0;
  endtask

  task automatic wr(logic [1:0] t, logic [31:0] d);
    cfg_we = 1; cfg_tgt = t; cfg_wdata = d;
    step("R7", 0, 0, 0, 0, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    check("R9", match_valid, 0, "reset match_valid");
    check("R9", match, 0, "reset match");
    rst_n = 1;
    @(negedge clk);

    // R1: reset masks demand full equality
    step("R1", 1, 0, 3, 32'h1234_5678, 32'h1234_5678);
    step("R1", 1, 0, 3, 32'h8234_5678, 32'h0234_5678);
    step("R1", 1, 0, 14, 32'h0000_0001, 32'h0);
    step("R1", 1, 0, 15, 32'h0000_1000, 32'h0);
    step("R9", 0, 0, 3, 0, 0);

    // R7: writes outside freeze and to the reserved slot are dropped
    freeze = 0; wr(2'd0, 32'h0);
    step("R7", 1, 0, 3, 32'hF000_0000, 0);
    freeze = 1; wr(2'd3, 32'h0);
    step("R7", 1, 0, 9, 32'h0000_0100, 0);
    step("R7", 1, 0, 14, 32'h0000_0100, 0);

    // program masks in freeze
    wr(2'd0, 32'h0000_FFFF); wr(2'd1, 32'hFFFF_0000); wr(2'd2, 32'h0);
    freeze = 0;
    step("R2", 1, 0, 5, 32'hABCD_0042, 32'h1111_0042);
    step("R2", 1, 0, 39, 32'h0000_0042, 32'h0000_0043);
    step("R3", 1, 0, 14, 32'h5555_1234, 32'h5555_0000);
    step("R3", 1, 0, 14, 32'h5554_1234, 32'h5555_1234);
    step("R3", 1, 0, 15, 32'hFFFF_FFFF, 32'h0);
    step("R8", 1, 0, 13, 32'h0000_8000, 32'h0);

    // FIFO filter table
    fifo_en = 1;
    step("R5", 1, 1, 6, 32'h7777_00FF, 32'h7777_FF00);
    step("R5", 1, 1, 6, 32'h7770_0000, 32'h7777_0000);
    step("R5", 1, 1, 7, 32'hDEAD_BEEF, 32'h0);
    step("R4", 1, 1, 2, 32'hAAAA_0001, 32'h5555_0001);
    step("R4", 1, 1, 0, 32'h0000_0001, 32'h0000_0000);
    step("R10", 1, 1, 8, 32'h0, 32'h0);
    fifo_en = 0;
    step("R10", 1, 1, 2, 32'h0, 32'h0);
    step("R10", 1, 0, 45, 32'h0, 32'h0);
    step("R10", 1, 0, 63, 32'h0, 32'h0);

    // individual masks
    indiv_mode = 1; indiv_mask = 32'h0;
    step("R6", 1, 0, 5, 32'hFFFF_FFFF, 32'h0);
    indiv_mask = '1;
    step("R6", 1, 0, 5, 32'h0001_0000, 32'h0);
    step("R6", 1, 0, 15, 32'h0000_0004, 32'h0);
    step("R6", 1, 0, 10, 32'h0000_0004, 32'h0000_0004);
    indiv_mode = 0;

    // R11: write and lookup together
    freeze = 1; cfg_we = 1; cfg_tgt = 2'd0; cfg_wdata = '1;
    step("R11", 1, 0, 5, 32'h1234_0000, 32'h0);
    step("R11", 1, 0, 5, 32'h1234_0000, 32'h0);
    freeze = 0;

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, sp;
      freeze = ($urandom % 4) == 0;
      cfg_we = ($urandom % 3) == 0;
      cfg_tgt = 2'($urandom);
      cfg_wdata = ~($urandom & $urandom & $urandom);
      indiv_mode = ($urandom % 5) == 0;
      fifo_en = ($urandom % 2) == 0;
      indiv_mask = ~($urandom & $urandom);
      r = $urandom;
      sp = ($urandom % 3 == 0) ? 32'h0 : ($urandom & $urandom & $urandom);
      step("R8", ($urandom % 6) != 0, 1'($urandom), ($urandom % 2) ? 6'($urandom % 18) : 6'($urandom),
           r, r ^ sp);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule